// File: doc/BRIEF.md
# Serial DAC Frame Write Master

This block takes one 16-bit word at a time from the system side and sends it to a serial-input digital-to-analog converter. It drives four lines: an active-low chip select, a frame strobe, a serial clock and a serial data line. Chip select drops first. The frame strobe then falls to open the frame. The serial clock starts high and produces sixteen falling edges. The converter samples one data bit on each falling edge, most significant bit first.

Every minimum interval is a parameter counted in system clock cycles. These are: chip select ahead of the strobe, strobe ahead of the first clock fall, clock high and low times, the gap from the last fall to a strobe-driven update, the gap from the update to chip-select release, and the strobe high time. A mode input chooses how the converter output is updated. With the mode low, a final rising clock edge follows the last bit. With the mode high, the strobe rises while the clock is held low. The mode is captured when the word is accepted.

The system side uses valid/ready. `req_ready` is high only when the block is idle. A word is taken on a clock edge where both `req_valid` and `req_ready` are high. While `req_ready` is low, the source must hold `req_valid` and `req_data` steady. `req_ready` stays low through the whole frame, including the closing strobe-high interval. A one-cycle `done` pulse marks the cycle in which `req_ready` returns.

Top module: `dac_frame_master`

## Requirements
- R1: `req_ready` is high only while chip select is released and no frame is in progress. A word is accepted when `req_valid` and `req_ready` are both high at a clock edge. From acceptance until the frame has fully ended, `req_ready` stays low and `busy` stays high.
- R2: `dac_cs_n` falls at least T_CSFS cycles before `dac_fs` falls.
- R3: `dac_sclk` is high whenever chip select is released. `dac_fs` is low for at least T_FSCK cycles before the first falling edge of `dac_sclk`.
- R4: Inside a frame, each high phase of `dac_sclk` lasts at least T_SCKH cycles and each low phase lasts at least T_SCKL cycles.
- R5: Each frame has exactly 16 falling edges of `dac_sclk`. The n-th falling edge carries bit 15-n+1 of the accepted word, so the first edge carries bit 15 and the last carries bit 0. `dac_din` never changes in the cycle of a falling edge or in the cycle after it.
- R6: With `upd_on_fs` = 0, the update is a rising `dac_sclk` edge after the 16th fall, while `dac_fs` is still low. With `upd_on_fs` = 1, the update is a rising `dac_fs` edge while `dac_sclk` is still low, at least T_C16FS cycles after the 16th fall.
- R7: `dac_cs_n` rises at least T_UPDCS cycles after the update event, and `dac_fs` is high when it does.
- R8: `dac_fs` stays high for at least T_FSH cycles before `req_ready` returns.
- R9: `done` is a single-cycle pulse in the cycle `req_ready` returns, once per frame.
- R10: After reset, `dac_cs_n`, `dac_fs`, `dac_sclk` and `req_ready` are 1 and `done` is 0.
- R11: Changing `upd_on_fs` after a word is accepted has no effect on that frame's update method.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Word offered by the source |
| req_ready | output | 1 | Block idle and able to take a word |
| req_data | input | WORD_W | Word to send, bit 15 sent first |
| upd_on_fs | input | 1 | Update method: 0 = clock edge, 1 = strobe edge |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse at end of frame |
| dac_cs_n | output | 1 | Chip select, active low |
| dac_fs | output | 1 | Frame strobe, low during the bit phase |
| dac_sclk | output | 1 | Serial clock, idles high |
| dac_din | output | 1 | Serial data, sampled by the converter on falling edges |

## Verification
The bench does not use the defaults. It builds the block with intervals that differ from one another: T_CSFS=2, T_FSCK=3, T_SCKH=2, T_SCKL=4, T_C16FS=5, T_UPDCS=2, T_FSH=3. Because these values differ, a mix-up between counters or an off-by-one in a reload shows up as a measured gap that is too short. Setting T_C16FS above T_SCKL lengthens the final low phase in strobe-update mode, so the bench can measure that last low phase separately from the ordinary ones.

// File: rtl/dfm_pkg.sv
package dfm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CS_LEAD,
    ST_FS_LEAD,
    ST_CLK_LOW,
    ST_CLK_HIGH,
    ST_UPDATE,
    ST_FS_HIGH
  } dfm_state_e;

  typedef enum logic {
    UPD_SCLK = 1'b0,
    UPD_FS   = 1'b1
  } dfm_upd_e;

  function automatic int dfm_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/dfm_timer.sv
module dfm_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

  // R4
  timer_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == $past(load_val)));
endmodule

// File: rtl/dfm_shifter.sv
module dfm_shifter #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] data,
  input  logic              shift,
  output logic              din,
  output logic              last
);
  localparam int IDX_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;

  logic [WORD_W-1:0] sh_q;
  logic [IDX_W-1:0]  idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      idx_q <= '0;
    end else if (load) begin
      sh_q  <= data;
      idx_q <= '0;
    end else if (shift) begin
      sh_q  <= {sh_q[WORD_W-2:0], 1'b0};
      idx_q <= idx_q + 1'b1;
    end
  end

  assign din  = sh_q[WORD_W-1];
  assign last = (idx_q == IDX_W'(WORD_W-1));

  // R5
  no_extra_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift |-> !last);
endmodule

// File: rtl/dfm_seq.sv
module dfm_seq
  import dfm_pkg::*;
#(
  parameter int T_CSFS  = 1,
  parameter int T_FSCK  = 1,
  parameter int T_SCKH  = 3,
  parameter int T_SCKL  = 3,
  parameter int T_C16FS = 1,
  parameter int T_UPDCS = 1,
  parameter int T_FSH   = 2,
  parameter int CNT_W   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             upd_on_fs,
  input  logic             tmr_expired,
  input  logic             last_bit,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             accept,
  output logic             shift,
  output logic             ready,
  output logic             done,
  output logic             cs_n,
  output logic             fs,
  output logic             sclk
);
  localparam int LAST_LOW = dfm_max(T_SCKL, T_C16FS);

  dfm_state_e state_q, state_d;
  dfm_upd_e   mode_q;
  logic       done_q, done_d;

  function automatic logic [CNT_W-1:0] dur(input int t);
    return CNT_W'(t - 1);
  endfunction

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    accept   = 1'b0;
    shift    = 1'b0;
    done_d   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          accept   = 1'b1;
          state_d  = ST_CS_LEAD;
          tmr_load = 1'b1;
          tmr_val  = dur(T_CSFS);
        end
      end
      ST_CS_LEAD: begin
        if (tmr_expired) begin
          state_d  = ST_FS_LEAD;
          tmr_load = 1'b1;
          tmr_val  = dur(T_FSCK);
        end
      end
      ST_FS_LEAD, ST_CLK_HIGH: begin
        if (tmr_expired) begin
          state_d  = ST_CLK_LOW;
          tmr_load = 1'b1;
          tmr_val  = last_bit ? dur(LAST_LOW) : dur(T_SCKL);
        end
      end
      ST_CLK_LOW: begin
        if (tmr_expired) begin
          tmr_load = 1'b1;
          if (last_bit) begin
            state_d = ST_UPDATE;
            tmr_val = dur(T_UPDCS);
          end else begin
            shift   = 1'b1;
            state_d = ST_CLK_HIGH;
            tmr_val = dur(T_SCKH);
          end
        end
      end
      ST_UPDATE: begin
        if (tmr_expired) begin
          state_d  = ST_FS_HIGH;
          tmr_load = 1'b1;
          tmr_val  = dur(T_FSH);
        end
      end
      ST_FS_HIGH: begin
        if (tmr_expired) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      mode_q  <= UPD_SCLK;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      if (accept) mode_q <= dfm_upd_e'(upd_on_fs);
    end
  end

  assign ready = (state_q == ST_IDLE);
  assign done  = done_q;
  assign cs_n  = (state_q == ST_IDLE) || (state_q == ST_FS_HIGH);
  assign fs    = !((state_q inside {ST_FS_LEAD, ST_CLK_LOW, ST_CLK_HIGH}) ||
                   (state_q == ST_UPDATE && mode_q == UPD_SCLK));
  assign sclk  = !((state_q == ST_CLK_LOW) ||
                   (state_q == ST_UPDATE && mode_q == UPD_FS));

  // R2
  cs_before_fs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fs) |-> (!cs_n && $past(!cs_n)));

  // R7
  cs_release_fs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> fs);

  // R11
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && !$past(ready)) |-> $stable(mode_q));
endmodule

// File: rtl/dac_frame_master.sv
module dac_frame_master #(
  parameter int WORD_W  = 16,
  parameter int T_CSFS  = 1,
  parameter int T_FSCK  = 1,
  parameter int T_SCKH  = 3,
  parameter int T_SCKL  = 3,
  parameter int T_C16FS = 1,
  parameter int T_UPDCS = 1,
  parameter int T_FSH   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [WORD_W-1:0] req_data,
  input  logic              upd_on_fs,
  output logic              busy,
  output logic              done,
  output logic              dac_cs_n,
  output logic              dac_fs,
  output logic              dac_sclk,
  output logic              dac_din
);
  import dfm_pkg::*;

  localparam int MAX_T = dfm_max(dfm_max(dfm_max(T_CSFS, T_FSCK), dfm_max(T_SCKH, T_SCKL)),
                                 dfm_max(dfm_max(T_C16FS, T_UPDCS), T_FSH));
  localparam int CNT_W = (MAX_T > 1) ? $clog2(MAX_T) + 1 : 1;

  logic             tmr_load, tmr_expired, accept, shift, last_bit;
  logic [CNT_W-1:0] tmr_val;

  dfm_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .expired(tmr_expired)
  );

  dfm_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(accept), .data(req_data), .shift(shift),
    .din(dac_din), .last(last_bit)
  );

  dfm_seq #(
    .T_CSFS(T_CSFS), .T_FSCK(T_FSCK), .T_SCKH(T_SCKH), .T_SCKL(T_SCKL),
    .T_C16FS(T_C16FS), .T_UPDCS(T_UPDCS), .T_FSH(T_FSH), .CNT_W(CNT_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .upd_on_fs(upd_on_fs),
    .tmr_expired(tmr_expired), .last_bit(last_bit), .tmr_load(tmr_load),
    .tmr_val(tmr_val), .accept(accept), .shift(shift), .ready(req_ready),
    .done(done), .cs_n(dac_cs_n), .fs(dac_fs), .sclk(dac_sclk)
  );

  assign busy = !req_ready;

  // R1
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_cs_n |-> (!req_ready && busy));

  // R3
  sclk_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dac_cs_n |-> dac_sclk);

  // R5
  din_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dac_sclk) |=> $stable(dac_din));

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (req_ready && $rose(req_ready)));
endmodule

// File: tb/tb_dac_frame_master.sv
module tb_dac_frame_master;
  localparam int T_CSFS = 2, T_FSCK = 3, T_SCKH = 2, T_SCKL = 4;
  localparam int T_C16FS = 5, T_UPDCS = 2, T_FSH = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, upd_on_fs = 1'b0;
  logic [15:0] req_data = '0;
  logic req_ready, busy, done, cs_n, fs, sclk, din;

  always #10 clk = ~clk;

  dac_frame_master #(
    .WORD_W(16), .T_CSFS(T_CSFS), .T_FSCK(T_FSCK), .T_SCKH(T_SCKH), .T_SCKL(T_SCKL),
    .T_C16FS(T_C16FS), .T_UPDCS(T_UPDCS), .T_FSH(T_FSH)
  ) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_data(req_data), .upd_on_fs(upd_on_fs), .busy(busy), .done(done),
    .dac_cs_n(cs_n), .dac_fs(fs), .dac_sclk(sclk), .dac_din(din)
  );

  int nchecks = 0, nfail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp_v);
    nchecks++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp_v);
    end
  endtask

  // Pin monitor, sampled at the falling clock edge
  int cyc = 0, t_cs = 0, t_fsf = 0, t_edge = 0, t_fsr = 0, t_upd = 0, t_lastfall = 0;
  int nfalls = 0, upd_kind = 0, frame_dones = 0;
  logic [15:0] cap = '0;
  int f_r2 = 0, f_r3 = 0, f_r4 = 0, f_r5 = 0, f_r6 = 0, f_r7 = 0, f_r8 = 0, f_r9 = 0;
  logic p_cs = 1, p_fs = 1, p_sclk = 1, p_din = 0, p_ready = 1, p_fell = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      p_cs = 1; p_fs = 1; p_sclk = 1; p_ready = 1; p_din = din; p_fell = 0;
    end else begin
      cyc++;
      if (cs_n && !sclk) f_r3++;
      if (p_fell && din !== p_din) f_r5++;
      p_fell = 0;
      if (p_cs && !cs_n) begin
        t_cs = cyc; nfalls = 0; cap = '0; upd_kind = 0; frame_dones = 0;
        f_r2 = 0; f_r3 = 0; f_r4 = 0; f_r5 = 0; f_r6 = 0; f_r7 = 0; f_r8 = 0; f_r9 = 0;
      end
      if (p_fs && !fs) begin
        t_fsf = cyc;
        if (cs_n || cyc - t_cs < T_CSFS) f_r2++;
      end
      if (p_sclk && !sclk) begin
        if (nfalls == 0) begin
          if (fs || cyc - t_fsf < T_FSCK) f_r3++;
        end else if (cyc - t_edge < T_SCKH) f_r4++;
        if (din !== p_din) f_r5++;
        cap = {cap[14:0], din};
        nfalls++;
        t_edge = cyc; t_lastfall = cyc; p_fell = 1;
      end
      if (!p_sclk && sclk) begin
        if (!cs_n && cyc - t_edge < T_SCKL) f_r4++;
        if (nfalls == 16 && upd_kind == 0) begin
          upd_kind = 1; t_upd = cyc;
          if (fs) f_r6++;
        end
        t_edge = cyc;
      end
      if (!p_fs && fs) begin
        t_fsr = cyc;
        if (nfalls == 16 && upd_kind == 0) begin
          upd_kind = 2; t_upd = cyc;
          if (sclk || cyc - t_lastfall < T_C16FS) f_r6++;
        end
      end
      if (!p_cs && cs_n) begin
        if (upd_kind == 0 || cyc - t_upd < T_UPDCS || !fs) f_r7++;
      end
      if (!p_ready && req_ready) begin
        if (!fs || cyc - t_fsr < T_FSH) f_r8++;
        if (!done) f_r9++;
      end else if (done) f_r9++;
      if (done) frame_dones++;
      p_cs = cs_n; p_fs = fs; p_sclk = sclk; p_din = din; p_ready = req_ready;
    end
  end

  task automatic send_frame(input logic [15:0] word, input bit mode, input bit flip, input string name);
    @(negedge clk);
    req_valid = 1; req_data = word; upd_on_fs = mode;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0; req_data = ~word;
    // R1: ready drops once the word is taken
    chk(!req_ready && busy, {name, " R1 ready low after accept"}, req_ready, 0);
    repeat (5) @(negedge clk);
    if (flip) upd_on_fs = ~mode;
    while (!done) @(negedge clk);
    @(negedge clk);
    chk(cap == word, {name, " R5 word captured"}, cap, word);
    chk(nfalls == 16, {name, " R5 falling edge count"}, nfalls, 16);
    chk(f_r5 == 0, {name, " R5 din hold"}, f_r5, 0);
    chk(upd_kind == (mode ? 2 : 1), {name, " R6 R11 update kind"}, upd_kind, mode ? 2 : 1);
    chk(f_r6 == 0, {name, " R6 update timing"}, f_r6, 0);
    chk(f_r2 == 0, {name, " R2 cs lead"}, f_r2, 0);
    chk(f_r3 == 0, {name, " R3 fs lead and idle clock"}, f_r3, 0);
    chk(f_r4 == 0, {name, " R4 clock phases"}, f_r4, 0);
    chk(f_r7 == 0, {name, " R7 cs release"}, f_r7, 0);
    chk(f_r8 == 0, {name, " R8 fs high time"}, f_r8, 0);
    chk(f_r9 == 0 && frame_dones == 1, {name, " R9 done pulse"}, frame_dones, 1);
    chk(req_ready && !done, {name, " R1 R9 idle after frame"}, req_ready, 1);
  endtask

  task automatic test_reset();
    @(negedge clk);
    // R10
    chk(cs_n && fs && sclk, "R10 line levels", {cs_n, fs, sclk}, 7);
    chk(req_ready && !busy && !done, "R10 handshake", {req_ready, busy, done}, 4);
  endtask

  task automatic test_sclk_update();
    send_frame(16'hA5C3, 1'b0, 1'b0, "sclk_mode");
    send_frame(16'h0000, 1'b0, 1'b0, "sclk_zero");
  endtask

  task automatic test_fs_update();
    send_frame(16'hFFFF, 1'b1, 1'b0, "fs_ones");
    send_frame(16'h8001, 1'b1, 1'b0, "fs_ends");
  endtask

  task automatic test_mode_flip();
    // R11
    send_frame(16'h3C96, 1'b0, 1'b1, "flip_to_fs");
    send_frame(16'h6A5F, 1'b1, 1'b1, "flip_to_sclk");
  endtask

  task automatic test_idle_hold();
    // R1: no valid, nothing moves
    repeat (10) @(negedge clk);
    chk(cs_n && fs && sclk && req_ready, "R1 idle without valid", {cs_n, fs, sclk, req_ready}, 15);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    test_reset();
    test_idle_hold();
    test_sclk_update();
    test_fs_update();
    test_mode_flip();
    send_frame(16'h1234, 1'b0, 1'b0, "back_to_back_a");
    send_frame(16'hFEDC, 1'b1, 1'b0, "back_to_back_b");
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nchecks++; nfail++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
      $finish;
    end
  end
endmodule